// File: doc/BRIEF.md
# Dynamic On-Die Termination Sequencer

This block holds the termination settings of a DDR3-style memory device and chooses, cycle by cycle, which termination strength the data pins present. A mode-register load captures a nominal termination code, a separate write-termination code, the CAS write latency and the termination-off latency. While no write is in progress the selector shows the nominal value. A decoded write command with dynamic termination enabled swaps the selector to the write value after a delay set by the write latency. It then swaps back after a delay set by the burst length and the off latency.

A write that arrives inside a running window restarts the return countdown from the new command, and the selector stays on the write value across the restart. Reserved nominal codes are shown as off and raised on a flag. A nominal code that is not legal for writes raises a one-cycle error pulse when a write uses it. A mode load whose latencies cannot give a valid window is refused and flagged.

Top module: `dyn_term_seq`

## Requirements
- R1: With no write window active, `term_sel` shows the nominal code taken from `mode_data` bits 9 (high), 6 and 2 (low). The output encoding is 0 = off, 1 = RZQ/4 (60 Ω), 2 = RZQ/2 (120 Ω), 3 = RZQ/6 (40 Ω), 4 = RZQ/12 (20 Ω) and 5 = RZQ/8 (30 Ω), with RZQ = 240 Ω. The new value appears in the cycle after the load edge.
- R2: Nominal codes 6 and 7 are reserved. `nom_rsv` is high while one is held, and `term_sel` shows 0 (off) in place of the nominal value.
- R3: `mode_data[11:10]` selects the write value: 01 = RZQ/4 (selector 1), 10 = RZQ/2 (selector 2), and 00 or 11 disables dynamic termination. With it enabled, a write registered at edge T switches `term_sel` to the write value at edge T + (write latency − 2).
- R4: After a write with 8-beat burst (`wr_chop4` = 0), `term_sel` returns to the nominal value at edge T + 6 + off latency.
- R5: After a write with 4-beat chop (`wr_chop4` = 1), `term_sel` returns to the nominal value at edge T + 4 + off latency.
- R6: A write registered inside a running window restarts the return count from its own edge, using its own burst length. The selector does not fall back to nominal between the two writes.
- R7: With dynamic termination disabled, write commands leave `term_sel` unchanged.
- R8: A write registered at edge T while dynamic termination is disabled and the nominal code is 4, 5, 6 or 7 sets `wr_nom_err` for exactly the cycle after T. Codes 0 to 3 never set it.
- R9: A mode load with write latency below 3, or with off latency + 6 not above the write latency, is refused. All held settings keep their old values and `cfg_err` goes high. An accepted load clears `cfg_err`.
- R10: Reset forces `term_sel` to 0, clears every flag and every pending window, and loads nominal off with dynamic termination disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Captures `mode_data` and both latencies |
| mode_data | input | 16 | Mode word: nominal code in bits 9/6/2, write code in 11:10 |
| cas_wr_lat | input | 4 | CAS write latency in cycles |
| odt_off_lat | input | 4 | Termination-off latency in cycles |
| wr_cmd | input | 1 | A write command of any variant is registered this cycle |
| wr_chop4 | input | 1 | 1 = 4-beat chop, 0 = 8-beat burst |
| term_sel | output | 3 | Encoded active termination |
| nom_rsv | output | 1 | Held nominal code is reserved |
| cfg_err | output | 1 | Last mode load was refused |
| wr_nom_err | output | 1 | Pulse: a write used a nominal code not legal for writes |

## Verification
Every result comes from one register stage. A mode load or write registered at edge T is first visible after edge T. The switch to the write value falls at T + write latency − 2, and the return falls at T + 6 or T + 4 plus the off latency. The bench drives on the falling edge and, after each write, samples `term_sel` on every falling edge j = 0..13 after T. Each sample is compared with the expectation for edge T + j taken from the table, so both the first and the last cycle of each window are compared exactly. The error pulse is sampled at j = 0 and must be gone at j = 1. The restart case is timed from the second write's own edge.

// File: rtl/dyn_term_pkg.sv
package dyn_term_pkg;

   localparam logic [2:0] TS_OFF   = 3'd0;
   localparam logic [2:0] TS_DIV4  = 3'd1;
   localparam logic [2:0] TS_DIV2  = 3'd2;

   // nominal codes 6 and 7 carry no strength
   function automatic logic nom_is_rsv(input logic [2:0] code);
      return code[2] & code[1];
   endfunction

   // strengths 4..7 may not be used as termination while writing
   function automatic logic nom_wr_illegal(input logic [2:0] code);
      return code[2];
   endfunction

   function automatic logic [2:0] nom_to_sel(input logic [2:0] code);
      return nom_is_rsv(code) ? TS_OFF : code;
   endfunction

   function automatic logic wr_code_on(input logic [1:0] code);
      return code[0] ^ code[1];
   endfunction

   function automatic logic [2:0] wr_to_sel(input logic [1:0] code);
      logic [2:0] sel;
      case (code)
         2'b01:   sel = TS_DIV4;
         2'b10:   sel = TS_DIV2;
         default: sel = TS_OFF;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/dyn_term_cfg.sv
module dyn_term_cfg
   import dyn_term_pkg::*;
#(
   parameter int MR_W    = 16,
   parameter int LAT_W   = 4,
   parameter int CNT_W   = 6,
   parameter int NOM_HI  = 9,
   parameter int NOM_MID = 6,
   parameter int NOM_LO  = 2,
   parameter int WR_LSB  = 10
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MR_W-1:0]  data,
   input  logic [LAT_W-1:0] wl_in,
   input  logic [LAT_W-1:0] off_in,
   output logic [2:0]       nom_code,
   output logic [1:0]       wr_code,
   output logic [LAT_W-1:0] cnw,
   output logic [CNT_W-1:0] ret8,
   output logic [CNT_W-1:0] ret4,
   output logic             cfg_err
);

   localparam int NOM_POS [3] = '{NOM_LO, NOM_MID, NOM_HI};

   if (NOM_HI >= MR_W || WR_LSB + 1 >= MR_W) begin : g_bad_pos
      $error("mode field position outside the mode word");
   end
   if (CNT_W <= LAT_W) begin : g_bad_cnt
      $error("counter width must exceed latency width");
   end

   logic [2:0] nom_in;
   for (genvar i = 0; i < 3; i++) begin : g_nom_bit
      assign nom_in[i] = data[NOM_POS[i]];
   end

   logic unused_mode_bits;
   assign unused_mode_bits = ^data;

   logic [CNT_W-1:0] wl_w, off_w;
   logic             load_ok;
   assign wl_w    = CNT_W'(wl_in);
   assign off_w   = CNT_W'(off_in);
   assign load_ok = (wl_w >= CNT_W'(3)) && ((off_w + CNT_W'(6)) > wl_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nom_code <= TS_OFF;
         wr_code  <= 2'b00;
         cnw      <= LAT_W'(1);
         ret8     <= CNT_W'(6);
         ret4     <= CNT_W'(4);
         cfg_err  <= 1'b0;
      end else if (load) begin
         if (load_ok) begin
            nom_code <= nom_in;
            wr_code  <= data[WR_LSB +: 2];
            cnw      <= wl_in - LAT_W'(2);
            ret8     <= off_w + CNT_W'(6);
            ret4     <= off_w + CNT_W'(4);
            cfg_err  <= 1'b0;
         end else begin
            cfg_err  <= 1'b1;
         end
      end
   end

   assert_reject_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (wl_in < LAT_W'(3))) |=> ($stable(nom_code) && $stable(cnw) && $stable(wr_code) && cfg_err));

   assert_cnw_positive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnw != '0) && (ret4 > CNT_W'(cnw)));

endmodule

// File: rtl/dyn_term_window.sv
module dyn_term_window #(
   parameter int LAT_W          = 4,
   parameter int CNT_W          = 6,
   parameter bit HOLD_ON_RETRIG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             chop4,
   input  logic [LAT_W-1:0] cnw,
   input  logic [CNT_W-1:0] ret8,
   input  logic [CNT_W-1:0] ret4,
   output logic             in_wr,
   output logic             busy
);

   logic [CNT_W-1:0] since_q, since_n, ret_q, ret_n, cnw_w;
   logic             hold_q, hold_n, busy_n, in_wr_n, in_span;

   assign cnw_w = CNT_W'(cnw);

   always_comb begin
      since_n = go ? '0 : (busy ? since_q + CNT_W'(1) : since_q);
      ret_n   = go ? (chop4 ? ret4 : ret8) : ret_q;
      busy_n  = go | (busy & ((since_q + CNT_W'(1)) < ret_q));
      in_span = (since_n >= cnw_w) && (since_n < ret_n);
   end

   if (HOLD_ON_RETRIG) begin : g_hold
      assign hold_n  = go ? in_wr : hold_q;
      assign in_wr_n = busy_n & (in_span | (hold_n & (since_n < cnw_w)));
   end else begin : g_plain
      assign hold_n  = 1'b0;
      assign in_wr_n = busy_n & in_span;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         ret_q   <= '0;
         hold_q  <= 1'b0;
         busy    <= 1'b0;
         in_wr   <= 1'b0;
      end else begin
         since_q <= since_n;
         ret_q   <= ret_n;
         hold_q  <= hold_n;
         busy    <= busy_n;
         in_wr   <= in_wr_n;
      end
   end

   assert_switch_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_wr) |-> (since_q == cnw_w));

   assert_window_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_wr) |-> !busy);

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (since_q < ret_q));

   assert_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && in_wr) |=> in_wr);

endmodule

// File: rtl/dyn_term_seq.sv
module dyn_term_seq
   import dyn_term_pkg::*;
#(
   parameter int MR_W  = 16,
   parameter int LAT_W = 4,
   parameter int CNT_W = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_load,
   input  logic [MR_W-1:0]  mode_data,
   input  logic [LAT_W-1:0] cas_wr_lat,
   input  logic [LAT_W-1:0] odt_off_lat,
   input  logic             wr_cmd,
   input  logic             wr_chop4,
   output logic [2:0]       term_sel,
   output logic             nom_rsv,
   output logic             cfg_err,
   output logic             wr_nom_err
);

   logic [2:0]       nom_code;
   logic [1:0]       wr_code;
   logic [LAT_W-1:0] cnw;
   logic [CNT_W-1:0] ret8, ret4;
   logic             dyn_on, win_go, win_in_wr, win_busy;

   dyn_term_cfg #(
      .MR_W(MR_W), .LAT_W(LAT_W), .CNT_W(CNT_W),
      .NOM_HI(9), .NOM_MID(6), .NOM_LO(2), .WR_LSB(10)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(mode_load), .data(mode_data),
      .wl_in(cas_wr_lat), .off_in(odt_off_lat),
      .nom_code(nom_code), .wr_code(wr_code), .cnw(cnw),
      .ret8(ret8), .ret4(ret4), .cfg_err(cfg_err)
   );

   assign dyn_on = wr_code_on(wr_code);
   assign win_go = wr_cmd & dyn_on;

   dyn_term_window #(
      .LAT_W(LAT_W), .CNT_W(CNT_W), .HOLD_ON_RETRIG(1'b1)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .go(win_go), .chop4(wr_chop4),
      .cnw(cnw), .ret8(ret8), .ret4(ret4),
      .in_wr(win_in_wr), .busy(win_busy)
   );

   assign nom_rsv  = nom_is_rsv(nom_code);
   assign term_sel = win_in_wr ? wr_to_sel(wr_code) : nom_to_sel(nom_code);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_nom_err <= 1'b0;
      else        wr_nom_err <= wr_cmd & ~dyn_on & nom_wr_illegal(nom_code);
   end

   assert_rsv_is_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nom_rsv && !win_in_wr) |-> (term_sel == TS_OFF));

   assert_disabled_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !dyn_on && !win_busy && !mode_load) |=> !win_in_wr);

   assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_nom_err |-> !$past(dyn_on));

endmodule

// File: tb/dyn_term_seq_bench.sv
module dyn_term_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_load = 1'b0;
   logic [15:0] mode_data = '0;
   logic [3:0]  cas_wr_lat = 4'd5;
   logic [3:0]  odt_off_lat = 4'd3;
   logic        wr_cmd = 1'b0;
   logic        wr_chop4 = 1'b0;
   logic [2:0]  term_sel;
   logic        nom_rsv, cfg_err, wr_nom_err;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dyn_term_seq u_dyn_term_seq (
      .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_data(mode_data),
      .cas_wr_lat(cas_wr_lat), .odt_off_lat(odt_off_lat),
      .wr_cmd(wr_cmd), .wr_chop4(wr_chop4),
      .term_sel(term_sel), .nom_rsv(nom_rsv), .cfg_err(cfg_err), .wr_nom_err(wr_nom_err)
   );

   // {nom[2:0], wr[1:0], chop4, wl[3:0], off[3:0], switch_j[3:0], return_j[3:0]}
   localparam int NV = 8;
   localparam logic [21:0] VEC [NV] = '{
      {3'b001, 2'b10, 1'b0, 4'd5, 4'd3, 4'd3,  4'd9},
      {3'b010, 2'b01, 1'b1, 4'd6, 4'd4, 4'd4,  4'd8},
      {3'b011, 2'b10, 1'b0, 4'd3, 4'd1, 4'd1,  4'd7},
      {3'b000, 2'b01, 1'b1, 4'd8, 4'd6, 4'd6,  4'd10},
      {3'b100, 2'b00, 1'b0, 4'd5, 4'd3, 4'd15, 4'd15},
      {3'b110, 2'b01, 1'b0, 4'd5, 4'd3, 4'd3,  4'd9},
      {3'b101, 2'b10, 1'b0, 4'd7, 4'd5, 4'd5,  4'd11},
      {3'b010, 2'b00, 1'b1, 4'd5, 4'd3, 4'd15, 4'd15}
   };

   function automatic logic [2:0] exp_nom(input logic [2:0] c);
      return (c == 3'd6 || c == 3'd7) ? 3'd0 : c;
   endfunction

   function automatic logic [2:0] exp_wr(input logic [1:0] w);
      return (w == 2'b01) ? 3'd1 : ((w == 2'b10) ? 3'd2 : 3'd0);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic load_mode(input logic [2:0] nom, input logic [1:0] wr,
                            input logic [3:0] wl, input logic [3:0] off);
      logic [15:0] md;
      md = 16'hA000;
      md[9] = nom[2];
      md[6] = nom[1];
      md[2] = nom[0];
      md[11:10] = wr;
      @(negedge clk);
      mode_load = 1'b1;
      mode_data = md;
      cas_wr_lat = wl;
      odt_off_lat = off;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R10: state during reset
      repeat (3) @(negedge clk);
      check("R10 term in reset", term_sel, 0);
      check("R10 flags in reset", {nom_rsv, cfg_err, wr_nom_err}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         logic [2:0] nom;
         logic [1:0] wr;
         logic       c4;
         int sw, rt;
         nom = VEC[v][21:19];
         wr  = VEC[v][18:17];
         c4  = VEC[v][16];
         sw  = int'(VEC[v][7:4]);
         rt  = int'(VEC[v][3:0]);
         load_mode(nom, wr, VEC[v][15:12], VEC[v][11:8]);
         check("R9 accepted load", cfg_err, 0);
         check("R1 idle nominal", term_sel, exp_nom(nom));
         check("R2 reserved flag", nom_rsv, (nom == 3'd6 || nom == 3'd7) ? 1 : 0);
         wr_cmd = 1'b1;
         wr_chop4 = c4;
         @(negedge clk);
         wr_cmd = 1'b0;
         for (int j = 0; j < 14; j++) begin
            string lbl;
            int    e;
            if (wr == 2'b00)  lbl = "R7";
            else if (j < sw)  lbl = "R1";
            else if (j < rt)  lbl = "R3";
            else              lbl = c4 ? "R5" : "R4";
            e = (j >= sw && j < rt) ? exp_wr(wr) : exp_nom(nom);
            check(lbl, term_sel, e);
            if (j == 0) check("R8 err pulse", wr_nom_err, (wr == 2'b00 && nom[2]) ? 1 : 0);
            if (j == 1) check("R8 err pulse ends", wr_nom_err, 0);
            @(negedge clk);
         end
      end

      // R9: refused loads keep the old setting (nominal 2 from last vector)
      load_mode(3'b001, 2'b10, 4'd2, 4'd3);
      check("R9 low latency refused", cfg_err, 1);
      check("R9 nominal kept", term_sel, 2);
      load_mode(3'b011, 2'b10, 4'd8, 4'd1);
      check("R9 short off latency refused", cfg_err, 1);
      check("R9 nominal kept again", term_sel, 2);

      // R6: retrigger inside a window, cnw 3, return 9
      load_mode(3'b001, 2'b10, 4'd5, 4'd3);
      check("R9 error cleared", cfg_err, 0);
      wr_cmd = 1'b1;
      wr_chop4 = 1'b0;
      @(negedge clk);
      wr_cmd = 1'b0;
      for (int j = 0; j < 18; j++) begin
         check("R6 retrigger", term_sel, (j >= 3 && j < 15) ? 2 : 1);
         if (j == 5) wr_cmd = 1'b1;
         if (j == 6) wr_cmd = 1'b0;
         @(negedge clk);
      end

      // R10: reset inside a window clears it
      wr_cmd = 1'b1;
      @(negedge clk);
      wr_cmd = 1'b0;
      repeat (4) @(negedge clk);
      check("R10 window active before reset", term_sel, 2);
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 term off in reset", term_sel, 0);
      rst_n = 1'b1;
      load_mode(3'b010, 2'b01, 4'd5, 4'd3);
      for (int j = 0; j < 12; j++) begin
         check("R10 no stale window", term_sel, 2);
         @(negedge clk);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule